// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one 16-bit compare channel for a timer/counter. The processor loads the compare value over an 8-bit bus. A high-byte write parks its byte in a temporary latch. The following low-byte write commits the whole 16-bit word in a single step.

In the two PWM modes the committed word goes to a shadow buffer. It reaches the active compare register only at the update point the timer reports, so a period or duty change never cuts a PWM cycle short. In the two non-PWM modes the shadow is bypassed and the word lands in the active register directly. The timer logic never changes the compare value on its own.

An equality comparator watches the running count. On a new match it emits a one-cycle match pulse and sets a sticky flag, which drives the interrupt request. The active compare value is exported so that a neighbouring counter can use it as its period.

Top module: `ocx_channel`

## Requirements
- R1: A synchronous active-low reset clears the active compare value, the shadow buffer, the high-byte latch, the match output and the flag to zero.
- R2: A strobe on `wr_hi_i` stores `dat_i` in the high-byte latch and changes neither the buffer nor `cmp_val_o`.
- R3: A strobe on `wr_lo_i` commits the word {latch, `dat_i`}. If `wr_hi_i` is strobed in the same cycle, the commit uses the latch contents from before that cycle.
- R4: With `mode_i` 2'b00 or 2'b01 (unbuffered), a commit appears on `cmp_val_o` after the next clock edge.
- R5: With `mode_i` 2'b10 or 2'b11 (buffered), a commit goes to the shadow buffer, and `cmp_val_o` holds its value in every cycle that has no update event.
- R6: The update event is `top_i` when `upd_bot_i` is 0 and `bot_i` when `upd_bot_i` is 1; the other event has no effect. On an update event the buffer is copied to `cmp_val_o`. If a commit arrives in the same cycle, the copy takes the buffer contents from before that commit.
- R7: While `mode_i` selects an unbuffered mode and no commit takes place, the buffer contents are copied into the active register on the next edge, so a value pending from a buffered mode is not lost.
- R8: `match_o` is high for exactly one cycle after a cycle in which `cnt_i` equals the active compare value. It does not rise again while `cnt_i` stays on that value.
- R9: The flag `flag_o` is set in the same cycle as `match_o` and stays set until it is cleared; `irq_o` follows the flag.
- R10: The flag clears on `irq_ack_i`, or on `flag_wr_i` with `dat_i[0]` = 1. A `flag_wr_i` with `dat_i[0]` = 0 has no effect.
- R11: When a clear and a new match fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dat_i | input | 8 | Processor write data |
| wr_hi_i | input | 1 | High-byte write strobe (to latch) |
| wr_lo_i | input | 1 | Low-byte write strobe (commits word) |
| flag_wr_i | input | 1 | Flag write strobe, clears on `dat_i[0]`=1 |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| mode_i | input | 2 | Operating mode, bit 1 set = buffered |
| upd_bot_i | input | 1 | Update point select: 0 on top, 1 on bottom |
| cnt_i | input | 16 | Current counter value |
| top_i | input | 1 | Counter at TOP this cycle |
| bot_i | input | 1 | Counter at BOTTOM this cycle |
| match_o | output | 1 | One-cycle match pulse |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |
| cmp_val_o | output | 16 | Active compare value (usable as period) |

## Verification
The bench attacks the same-cycle collisions of this block. A commit that meets an update event must still transfer the old buffer; a design that forwards the new word would end a PWM period early. A match that meets a clear must leave the flag set; a design that lets the clear win would lose an interrupt. Other targets are a counter that parks on the compare value, which a level-based design would report every cycle, and a low-byte write with no earlier high-byte write, which must use a zero high byte. The bench also switches out of a buffered mode with a value still pending, which a design without the copy-back would drop.

// File: rtl/ocx_pkg.sv
// Shared definitions for the timer compare channel.
// Assumes the compare word is exactly two bus bytes wide.
package ocx_pkg;

    localparam int BUS_W    = 8;
    localparam int CMP_W    = 2 * BUS_W;
    localparam int FLAG_BIT = 0;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'b00,
        MODE_CLRMAT  = 2'b01,
        MODE_PWM_SGL = 2'b10,
        MODE_PWM_DBL = 2'b11
    } ocx_mode_e;

    // True for the modes that route writes through the shadow buffer.
    function automatic logic mode_buffered(ocx_mode_e m);
        return (m == MODE_PWM_SGL) || (m == MODE_PWM_DBL);
    endfunction

endpackage

// File: rtl/ocx_byte_join.sv
// Assembles a wide word from two byte writes through a high-byte latch.
// Assumes the low-byte write is the commit; the latch keeps its value after a commit.
module ocx_byte_join #(
    parameter int BUS_W = 8,
    localparam int WORD_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  dat_i,
    input  logic              wr_hi_i,
    output logic [BUS_W-1:0]  tmp_o,
    output logic [WORD_W-1:0] word_o
);

    logic [BUS_W-1:0] tmp_q;

    // Capture the high byte on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmp_q <= '0;
        else if (wr_hi_i) tmp_q <= dat_i;
    end

    // The word presented for commit pairs the latched byte with the bus.
    always_comb word_o = {tmp_q, dat_i};

    assign tmp_o = tmp_q;

endmodule

// File: rtl/ocx_value_regs.sv
// Holds the shadow buffer and the active compare register.
// Assumes 'buffered' is decoded from the mode and 'upd_evt_i' is already the selected event.
module ocx_value_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buffered_i,
    input  logic         commit_i,
    input  logic [W-1:0] word_i,
    input  logic         upd_evt_i,
    output logic [W-1:0] act_o
);

    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;

    // Shadow buffer: takes every commit, in all modes, so it mirrors the last write.
    always_ff @(posedge clk) begin
        if (!rst_n)        buf_q <= '0;
        else if (commit_i) buf_q <= word_i;
    end

    // Active register: direct load when unbuffered, otherwise copy at the update event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (buffered_i) begin
            if (upd_evt_i) act_q <= buf_q;
        end else begin
            act_q <= commit_i ? word_i : buf_q;
        end
    end

    assign act_o = act_q;

endmodule

// File: rtl/ocx_match_unit.sv
// Compares the count with the active value and forms a first-hit pulse.
// Assumes a repeated identical count means a stopped counter, not a new hit.
module ocx_match_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    output logic         hit_now_o,
    output logic         match_o
);

    logic         eq;
    logic         eq_q;
    logic [W-1:0] cnt_q;
    logic         match_q;

    // A new hit is equality that was not already seen on this same count.
    always_comb begin
        eq        = (cnt_i == cmp_i);
        hit_now_o = eq && !(eq_q && (cnt_i == cnt_q));
    end

    // Remember the last comparison and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q    <= 1'b0;
            cnt_q   <= '0;
            match_q <= 1'b0;
        end else begin
            eq_q    <= eq;
            cnt_q   <= cnt_i;
            match_q <= hit_now_o;
        end
    end

    assign match_o = match_q;

endmodule

// File: rtl/ocx_flag_unit.sv
// Sticky compare flag with set priority over clear.
// Assumes the clear request is already qualified (acknowledge or write of one).
module ocx_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Set wins over clear; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/ocx_channel.sv
// Top of the compare channel: byte assembly, buffered compare value, match and flag.
// Assumes top_i/bot_i are single-cycle strobes from the counter.
module ocx_channel
    import ocx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] dat_i,
    input  logic             wr_hi_i,
    input  logic             wr_lo_i,
    input  logic             flag_wr_i,
    input  logic             irq_ack_i,
    input  logic [1:0]       mode_i,
    input  logic             upd_bot_i,
    input  logic [CMP_W-1:0] cnt_i,
    input  logic             top_i,
    input  logic             bot_i,
    output logic             match_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic [CMP_W-1:0] cmp_val_o
);

    logic [BUS_W-1:0] tmp_q;
    logic [CMP_W-1:0] word;
    logic             buffered;
    logic             upd_evt;
    logic             hit_now;
    logic             flag_clr;

    // Decode mode, update event and flag clear request.
    always_comb begin
        buffered = mode_buffered(ocx_mode_e'(mode_i));
        upd_evt  = upd_bot_i ? bot_i : top_i;
        flag_clr = irq_ack_i | (flag_wr_i & dat_i[FLAG_BIT]);
    end

    ocx_byte_join #(.BUS_W(BUS_W)) u_join (
        .clk     (clk),
        .rst_n   (rst_n),
        .dat_i   (dat_i),
        .wr_hi_i (wr_hi_i),
        .tmp_o   (tmp_q),
        .word_o  (word)
    );

    ocx_value_regs #(.W(CMP_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .buffered_i (buffered),
        .commit_i   (wr_lo_i),
        .word_i     (word),
        .upd_evt_i  (upd_evt),
        .act_o      (cmp_val_o)
    );

    ocx_match_unit #(.W(CMP_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt_i),
        .cmp_i     (cmp_val_o),
        .hit_now_o (hit_now),
        .match_o   (match_o)
    );

    ocx_flag_unit u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit_now),
        .clr_i  (flag_clr),
        .flag_o (flag_o)
    );

    assign irq_o = flag_o;

endmodule

// File: rtl/ocx_channel_chk.sv
// Property checker for the compare channel, bound to the top module.
module ocx_channel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  dat_i,
    input logic        wr_lo_i,
    input logic        irq_ack_i,
    input logic [1:0]  mode_i,
    input logic        upd_bot_i,
    input logic [15:0] cnt_i,
    input logic        top_i,
    input logic        bot_i,
    input logic        match_o,
    input logic        flag_o,
    input logic [15:0] cmp_val_o,
    input logic [7:0]  tmp_q
);

    // R4: unbuffered commit shows up after one edge
    p_unbuf_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[1] && wr_lo_i) |=> (cmp_val_o == {$past(tmp_q), $past(dat_i)}));

    // R5: buffered value holds without an update event
    p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && !(upd_bot_i ? bot_i : top_i)) |=> $stable(cmp_val_o));

    // R8: no second pulse on an unchanged count
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && $past(match_o)) |-> ($past(cnt_i) != $past(cnt_i, 2)));

    // R9: flag is set whenever the pulse is out
    p_flag_with_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> flag_o);

    // R10: acknowledge clears the flag unless a match arrives
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_ack_i) && !match_o) |-> !flag_o);

endmodule

bind ocx_channel ocx_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_i     (dat_i),
    .wr_lo_i   (wr_lo_i),
    .irq_ack_i (irq_ack_i),
    .mode_i    (mode_i),
    .upd_bot_i (upd_bot_i),
    .cnt_i     (cnt_i),
    .top_i     (top_i),
    .bot_i     (bot_i),
    .match_o   (match_o),
    .flag_o    (flag_o),
    .cmp_val_o (cmp_val_o),
    .tmp_q     (tmp_q)
);

// File: tb/ocx_channel_tb_top.sv
module ocx_channel_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dat_i = '0;
    logic        wr_hi_i = 1'b0, wr_lo_i = 1'b0, flag_wr_i = 1'b0, irq_ack_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        upd_bot_i = 1'b0;
    logic [15:0] cnt_i = 16'hFFFF;
    logic        top_i = 1'b0, bot_i = 1'b0;
    logic        match_o, flag_o, irq_o;
    logic [15:0] cmp_val_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0]  m_tmp;
    logic [15:0] m_buf, m_act, m_cnt;
    logic        m_eq, m_match, m_flag;

    always #(CLK_P/2) clk = ~clk;

    ocx_channel dut_i (
        .clk(clk), .rst_n(rst_n), .dat_i(dat_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
        .flag_wr_i(flag_wr_i), .irq_ack_i(irq_ack_i), .mode_i(mode_i), .upd_bot_i(upd_bot_i),
        .cnt_i(cnt_i), .top_i(top_i), .bot_i(bot_i), .match_o(match_o), .flag_o(flag_o),
        .irq_o(irq_o), .cmp_val_o(cmp_val_o)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance the reference by one edge from the requirements.
    task automatic model_edge();
        logic [15:0] word;
        logic        hit, eq, clr;
        if (!rst_n) begin
            m_tmp = '0; m_buf = '0; m_act = '0; m_cnt = '0;
            m_eq = 1'b0; m_match = 1'b0; m_flag = 1'b0;
            return;
        end
        eq   = (cnt_i == m_act);
        hit  = eq && !(m_eq && cnt_i == m_cnt);
        clr  = irq_ack_i || (flag_wr_i && dat_i[0]);
        word = {m_tmp, dat_i};
        m_flag  = hit ? 1'b1 : (clr ? 1'b0 : m_flag);
        m_match = hit;
        m_eq    = eq;
        m_cnt   = cnt_i;
        if (mode_i[1]) begin
            if (upd_bot_i ? bot_i : top_i) m_act = m_buf;
        end else begin
            m_act = wr_lo_i ? word : m_buf;
        end
        if (wr_lo_i) m_buf = word;
        if (wr_hi_i) m_tmp = dat_i;
    endtask

    // One cycle: edge, reference update, compare at the falling edge.
    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(req, "match_o", {15'd0, match_o}, {15'd0, m_match});
        chk(req, "flag_o", {15'd0, flag_o}, {15'd0, m_flag});
        chk(req, "irq_o", {15'd0, irq_o}, {15'd0, m_flag});
        chk(req, "cmp_val_o", cmp_val_o, m_act);
    endtask

    task automatic idle();
        wr_hi_i = 0; wr_lo_i = 0; flag_wr_i = 0; irq_ack_i = 0; top_i = 0; bot_i = 0;
    endtask

    task automatic write_word(logic [15:0] w, string req);
        dat_i = w[15:8]; wr_hi_i = 1; step(req); idle();
        dat_i = w[7:0];  wr_lo_i = 1; step(req); idle();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step("R1"); step("R1");
        rst_n = 1'b1;
        chk("R1", "cmp_val_o", cmp_val_o, 16'h0000);
        chk("R1", "flag_o", {15'd0, flag_o}, 16'h0000);
        chk("R1", "match_o", {15'd0, match_o}, 16'h0000);

        // R1/R3: low byte alone uses a cleared latch
        dat_i = 8'h5A; wr_lo_i = 1; step("R3"); idle();
        chk("R3", "lo only", cmp_val_o, 16'h005A);
        // R2: high byte alone commits nothing
        dat_i = 8'h12; wr_hi_i = 1; step("R2"); idle();
        chk("R2", "hi only", cmp_val_o, 16'h005A);
        // R3: hi and lo in same cycle use the old latch
        dat_i = 8'h34; wr_hi_i = 1; wr_lo_i = 1; step("R3"); idle();
        chk("R4", "direct", cmp_val_o, 16'h1234);

        // R5/R6: buffered, update on top
        mode_i = 2'b10; upd_bot_i = 0;
        write_word(16'hABCD, "R5");
        chk("R5", "buffered hold", cmp_val_o, 16'h1234);
        bot_i = 1; step("R6"); idle();
        chk("R6", "bottom ignored", cmp_val_o, 16'h1234);
        top_i = 1; step("R6"); idle();
        chk("R6", "top update", cmp_val_o, 16'hABCD);

        // R6: update on bottom, collision with a commit
        mode_i = 2'b11; upd_bot_i = 1;
        write_word(16'h0102, "R6");
        top_i = 1; step("R6"); idle();
        chk("R6", "top ignored", cmp_val_o, 16'hABCD);
        dat_i = 8'h03; wr_hi_i = 1; step("R6"); idle();
        dat_i = 8'h04; wr_lo_i = 1; bot_i = 1; step("R6"); idle();
        chk("R6", "collision keeps old buffer", cmp_val_o, 16'h0102);

        // R7: leaving buffered mode copies pending value
        mode_i = 2'b01; step("R7");
        chk("R7", "copy on leave", cmp_val_o, 16'h0304);

        // R8/R9: match pulse on a parked counter
        cnt_i = 16'h0304; step("R8");
        chk("R8", "first hit", {15'd0, match_o}, 16'h0001);
        chk("R9", "flag set", {15'd0, flag_o}, 16'h0001);
        chk("R9", "irq", {15'd0, irq_o}, 16'h0001);
        step("R8");
        chk("R8", "parked no pulse", {15'd0, match_o}, 16'h0000);
        chk("R9", "flag sticky", {15'd0, flag_o}, 16'h0001);

        // R10: write of zero ignored, write of one clears
        flag_wr_i = 1; dat_i = 8'hFE; step("R10"); idle();
        chk("R10", "write zero", {15'd0, flag_o}, 16'h0001);
        flag_wr_i = 1; dat_i = 8'h01; step("R10"); idle();
        chk("R10", "write one", {15'd0, flag_o}, 16'h0000);

        // R11: match beats acknowledge
        cnt_i = 16'h0000; step("R11");
        cnt_i = 16'h0304; irq_ack_i = 1; step("R11"); idle();
        chk("R11", "set wins", {15'd0, flag_o}, 16'h0001);
        irq_ack_i = 1; step("R10"); idle();
        chk("R10", "ack clears", {15'd0, flag_o}, 16'h0000);

        // randomised traffic against the reference
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 63) == 0) mode_i = 2'($urandom);
            if ($urandom_range(0, 127) == 0) upd_bot_i = ~upd_bot_i;
            dat_i     = 8'($urandom);
            wr_hi_i   = ($urandom_range(0, 5) == 0);
            wr_lo_i   = ($urandom_range(0, 5) == 0);
            top_i     = ($urandom_range(0, 7) == 0);
            bot_i     = ($urandom_range(0, 7) == 0);
            flag_wr_i = ($urandom_range(0, 9) == 0);
            irq_ack_i = ($urandom_range(0, 9) == 0);
            if (r < 33)      cnt_i = cnt_i;
            else if (r < 66) cnt_i = m_act;
            else             cnt_i = 16'($urandom);
            step("RND");
        end
        idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL WATCHDOG: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule